// File: doc/BRIEF.md
# Multiplexed Cartridge Bus Target

This block sits on the cartridge side of a 16-bit bus that carries both address and data on the same lines. The host sends a 32-bit byte address in two halves. While both the frame strobe and the upper strobe are high, the lines hold the upper half, which is latched when the upper strobe falls. While the frame strobe is high and the upper strobe is low, the lines hold the lower half, which is latched when the frame strobe falls. After that, each low pulse of the active-low read strobe returns one 16-bit word from an internal read-only array, and the address moves on by one word.

All bus pins are asynchronous to the fast internal clock. They pass through two-flop synchronisers, and edges are detected on the synchronised copies. The bidirectional pad itself lies outside this block. The block presents the data to return and an enable that turns the pad driver on. It drives only while a read is in progress to a selected upper half. A burst may contain at most 256 served reads. Each new frame phase starts the count again. There is no flow control: a read pulse must simply last long enough for the synchroniser and the array lookup.

Top module: `cart_bus_target`

## Requirements
- R1: The upper address half is taken from the AD lines when the upper strobe falls while the frame strobe is high. The lower half is taken when the frame strobe falls while the upper strobe is low.
- R2: The block is selected only when bits [15:8] of the captured upper half equal 0x10. Reads to any other upper half leave the drive enable low.
- R3: A served read returns, on ad_o, the word at index k = (byte address >> 1) mod 512. Its value is ((k * 257) mod 65536) XOR 0x5A00.
- R4: After each served read's strobe rises, the byte address advances by 2. Sequential reads therefore return consecutive indices, and a carry out of the lower half propagates into the upper half.
- R5: ad_oe_o is low after reset. It is high only while a served read strobe is low, and it returns low once the strobe has risen.
- R6: A frame strobe fall resets the burst count. Once 256 reads have been served, further reads leave the bus undriven and do not move the address until the next frame phase.
- R7: A read strobe that falls while the write strobe is low is ignored. It causes no drive and no address step.
- R8: After the read strobe falls, ad_oe_o is still low after two internal clock edges and is high with valid data after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb_i | input | 1 | Frame address strobe; its fall latches the lower half |
| upper_stb_i | input | 1 | Upper address strobe; its fall latches the upper half |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe; it blocks reads while low |
| ad_i | input | 16 | AD lines as seen at the pad input |
| ad_o | output | 16 | Data word to drive onto the AD lines |
| ad_oe_o | output | 1 | Pad output enable for ad_o |

## Verification
The hardest state to reach is the burst limit. Reaching it takes 256 complete, correctly spaced read pulses after one frame phase before the 257th read can show the bus left undriven. The bench runs a directed loop that performs exactly that many reads and checks the last served word. It then issues a fresh frame phase and confirms that reads are served again. Reaching a carry from the lower half into the upper half, and the wrap of the array index, needs chosen start addresses, and the vector table holds those.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  // Content of the read-only array, computed from the word index.
  function automatic logic [15:0] cbt_rom_word(input logic [31:0] k);
    logic [31:0] prod;
    prod = k * 32'd257;
    return prod[15:0] ^ 16'h5A00;
  endfunction
endpackage

// File: rtl/cbt_strobe_sync.sv
module cbt_strobe_sync #(
  parameter int             W       = 4,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
      dly_q  <= RST_VAL;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      dly_q  <= sync_q;
    end
  end

  assign lvl_o  = dly_q;
  assign rise_o = sync_q & ~dly_q;
  assign fall_o = ~sync_q & dly_q;
endmodule

// File: rtl/cbt_addr_tracker.sv
module cbt_addr_tracker #(
  parameter int         IDX_W     = 9,
  parameter int         BURST_MAX = 256,
  parameter logic [7:0] SEL_TAG   = 8'h10,
  localparam int        CNT_W     = $clog2(BURST_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      ad_s,
  input  logic             frame_lvl,
  input  logic             frame_fall,
  input  logic             upper_lvl,
  input  logic             upper_fall,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             sel,
  output logic             exhausted,
  output logic [CNT_W-1:0] burst_cnt
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(BURST_MAX);

  logic [31:0]      addr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (step) begin
        addr_q <= addr_q + 32'd2;
        cnt_q  <= cnt_q + 1'b1;
      end
      if (upper_fall && frame_lvl) addr_q[31:16] <= ad_s;
      if (frame_fall && !upper_lvl) begin
        addr_q[15:0] <= ad_s;
        cnt_q        <= '0;
      end
    end
  end

  assign idx       = addr_q[IDX_W:1];
  assign sel       = (addr_q[31:24] == SEL_TAG);
  assign exhausted = (cnt_q == CAP);
  assign burst_cnt = cnt_q;
endmodule

// File: rtl/cbt_rom.sv
module cbt_rom #(
  parameter int  WORDS = 512,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [15:0]      data_q
);
  import cbt_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  data_q <= '0;
    else if (en) data_q <= cbt_rom_word(32'(idx));
  end
endmodule

// File: rtl/cart_bus_target.sv
module cart_bus_target #(
  parameter int         ROM_WORDS = 512,
  parameter int         BURST_MAX = 256,
  parameter logic [7:0] SEL_TAG   = 8'h10,
  localparam int        IDX_W     = $clog2(ROM_WORDS),
  localparam int        CNT_W     = $clog2(BURST_MAX + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_stb_i,
  input  logic        upper_stb_i,
  input  logic        rd_n_i,
  input  logic        wr_n_i,
  input  logic [15:0] ad_i,
  output logic [15:0] ad_o,
  output logic        ad_oe_o
);
  // bit order of the synchronised strobe vector
  localparam int B_FRAME = 0;
  localparam int B_UPPER = 1;
  localparam int B_RD    = 2;
  localparam int B_WR    = 3;

  logic [3:0]       stb_lvl, stb_rise, stb_fall;
  logic [15:0]      ad_m, ad_s;
  logic [IDX_W-1:0] idx;
  logic             sel, exhausted, start, oe_q, served_rise;
  logic [CNT_W-1:0] burst_cnt;

  cbt_strobe_sync #(.W(4), .RST_VAL(4'b1100)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({wr_n_i, rd_n_i, upper_stb_i, frame_stb_i}),
    .lvl_o  (stb_lvl),
    .rise_o (stb_rise),
    .fall_o (stb_fall)
  );

  // AD delayed by the same two stages as the strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad_m <= '0;
      ad_s <= '0;
    end else begin
      ad_m <= ad_i;
      ad_s <= ad_m;
    end
  end

  cbt_addr_tracker #(.IDX_W(IDX_W), .BURST_MAX(BURST_MAX), .SEL_TAG(SEL_TAG)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ad_s      (ad_s),
    .frame_lvl (stb_lvl[B_FRAME]),
    .frame_fall(stb_fall[B_FRAME]),
    .upper_lvl (stb_lvl[B_UPPER]),
    .upper_fall(stb_fall[B_UPPER]),
    .step      (served_rise),
    .idx       (idx),
    .sel       (sel),
    .exhausted (exhausted),
    .burst_cnt (burst_cnt)
  );

  assign start       = stb_fall[B_RD] && stb_lvl[B_WR] && sel && !exhausted;
  assign served_rise = stb_rise[B_RD] && oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              oe_q <= 1'b0;
    else if (start)          oe_q <= 1'b1;
    else if (stb_rise[B_RD]) oe_q <= 1'b0;
  end

  cbt_rom #(.WORDS(ROM_WORDS)) u_rom (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (start),
    .idx   (idx),
    .data_q(ad_o)
  );

  assign ad_oe_o = oe_q;
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker #(
  parameter int BURST_MAX = 256,
  localparam int CNT_W    = $clog2(BURST_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ad_oe_o,
  input logic             rd_lvl,
  input logic             wr_lvl,
  input logic             rd_fall,
  input logic             sel,
  input logic             served_rise,
  input logic             frame_fall,
  input logic             upper_lvl,
  input logic             upper_fall,
  input logic [31:0]      addr,
  input logic [CNT_W-1:0] burst_cnt
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(BURST_MAX);

  assert_oe_needs_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_o |-> !rd_lvl);

  assert_oe_needs_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe_o) |-> $past(sel));

  assert_count_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_cnt <= CAP);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_fall && !upper_lvl) |=> (burst_cnt == '0));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (served_rise && !frame_fall && !upper_fall) |=> (addr == $past(addr) + 32'd2));

  assert_write_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && !wr_lvl) |=> !ad_oe_o);
endmodule

bind cart_bus_target cbt_checker #(.BURST_MAX(BURST_MAX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ad_oe_o    (ad_oe_o),
  .rd_lvl     (stb_lvl[2]),
  .wr_lvl     (stb_lvl[3]),
  .rd_fall    (stb_fall[2]),
  .sel        (sel),
  .served_rise(served_rise),
  .frame_fall (stb_fall[0]),
  .upper_lvl  (stb_lvl[1]),
  .upper_fall (stb_fall[1]),
  .addr       (u_trk.addr_q),
  .burst_cnt  (burst_cnt)
);

// File: tb/cart_bus_target_tb_top.sv
`timescale 1ns/1ps
module cart_bus_target_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_stb = 1'b0, upper_stb = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_o;
  logic        ad_oe_o;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cart_bus_target dut_i (
    .clk(clk), .rst_n(rst_n), .frame_stb_i(frame_stb), .upper_stb_i(upper_stb),
    .rd_n_i(rd_n), .wr_n_i(wr_n), .ad_i(ad_in), .ad_o(ad_o), .ad_oe_o(ad_oe_o)
  );

  typedef struct packed {
    logic [15:0] up;
    logic [15:0] lo;
    logic [8:0]  n;
    logic        sel;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{16'h1000, 16'h0000, 9'd4, 1'b1},
    '{16'h10AB, 16'h01F0, 9'd6, 1'b1},
    '{16'h1020, 16'hFFFC, 9'd4, 1'b1},
    '{16'h2000, 16'h0010, 9'd3, 1'b0},
    '{16'h1000, 16'h03FE, 9'd3, 1'b1}
  };

  function automatic logic [15:0] exp_word(input logic [31:0] byte_addr);
    logic [31:0] k, p;
    k = (byte_addr >> 1) % 512;
    p = k * 32'd257;
    return p[15:0] ^ 16'h5A00;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [15:0] up, input logic [15:0] lo);
    @(negedge clk); frame_stb = 1'b1; upper_stb = 1'b1; ad_in = up;
    repeat (4) @(negedge clk); upper_stb = 1'b0;
    repeat (4) @(negedge clk); ad_in = lo;
    repeat (4) @(negedge clk); frame_stb = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic do_read(output logic early, output logic oe, output logic [15:0] d,
                         output logic after);
    @(negedge clk); rd_n = 1'b0;
    repeat (2) @(negedge clk); early = ad_oe_o;
    @(negedge clk); oe = ad_oe_o; d = ad_o;
    repeat (3) @(negedge clk); rd_n = 1'b1;
    repeat (5) @(negedge clk); after = ad_oe_o;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic        e, o, a;
    logic [15:0] d;
    logic [31:0] addr;
    repeat (3) @(negedge clk);
    chk(ad_oe_o == 1'b0, "R5 reset oe", 32'(ad_oe_o), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2: after reset the address is unselected
    do_read(e, o, d, a);
    chk(o == 1'b0, "R2 read before address", 32'(o), 32'd0);

    // vector table: R1 capture, R2 select, R3 data, R4 stepping
    for (int v = 0; v < NV; v++) begin
      addr_phase(VECS[v].up, VECS[v].lo);
      addr = {VECS[v].up, VECS[v].lo};
      for (int r = 0; r < int'(VECS[v].n); r++) begin
        do_read(e, o, d, a);
        chk(o == VECS[v].sel, "R1/R2 drive enable", 32'(o), 32'(VECS[v].sel));
        if (VECS[v].sel) begin
          chk(d == exp_word(addr), "R3 R4 word", 32'(d), 32'(exp_word(addr)));
          addr = addr + 32'd2;
        end
        chk(a == 1'b0, "R5 release", 32'(a), 32'd0);
      end
    end

    // R8 latency
    addr_phase(16'h1000, 16'h0100);
    do_read(e, o, d, a);
    chk(e == 1'b0, "R8 early", 32'(e), 32'd0);
    chk(o == 1'b1, "R8 on time", 32'(o), 32'd1);

    // R7 write low blocks the read and does not move the address
    addr_phase(16'h1000, 16'h0040);
    @(negedge clk); wr_n = 1'b0;
    repeat (3) @(negedge clk);
    do_read(e, o, d, a);
    chk(o == 1'b0, "R7 blocked", 32'(o), 32'd0);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(e, o, d, a);
    chk(o == 1'b1 && d == exp_word(32'h1000_0040), "R7 address held", 32'(d),
        32'(exp_word(32'h1000_0040)));

    // R6 burst limit and restart
    addr_phase(16'h1000, 16'h0000);
    addr = 32'h1000_0000;
    for (int r = 0; r < 256; r++) begin
      do_read(e, o, d, a);
      if (r == 255)
        chk(o == 1'b1 && d == exp_word(addr), "R6 last served", 32'(d), 32'(exp_word(addr)));
      addr = addr + 32'd2;
    end
    do_read(e, o, d, a);
    chk(o == 1'b0, "R6 beyond cap", 32'(o), 32'd0);
    addr_phase(16'h1000, 16'h0002);
    do_read(e, o, d, a);
    chk(o == 1'b1 && d == exp_word(32'h1000_0002), "R6 restart", 32'(d),
        32'(exp_word(32'h1000_0002)));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule